// File: doc/BRIEF.md
# Instrument Status Byte Reporting Unit

This block builds the 8-bit status byte that a remotely programmed instrument hands to its host. It keeps a sticky standard event register, in which every bit is set by a one-cycle pulse from the rest of the instrument. An enable mask selects which of those bits feed a summary bit. The block also takes an already-masked questionable-status summary and a message-available level from the output buffer. A second mask decides which status byte bits raise the request-service bit.

Host-side logic drives plain strobes for these commands: read of the event register (which clears it), clear-status, writes of the two masks and a write of a power-on-clear flag. A power-on event input clears the event register. It clears both masks only when the stored flag is 1. The masks and the flag live on a cold reset domain, so a warm reset leaves them intact. The summary bits are formed combinationally from current state. They are never latched.

Top module: `status_byte_unit`

## Requirements
- R1: The status byte carries the questionable summary input on bit 3 (weight 8), message-available on bit 4 (weight 16), the standard-event summary on bit 5 (weight 32) and request-service on bit 6 (weight 64).
- R2: Status byte bits 0, 1, 2 and 7 always read as zero.
- R3: Summary bits are not latched: questionable and message-available inputs appear on the status byte in the same cycle, and clearing the event register drops bit 5 from the cycle after the clearing strobe.
- R4: Bit 5 is 1 exactly when some event register bit and its event-enable bit are both 1.
- R5: Event bit i (weight 2^i) is set by a one-cycle pulse on `evt_pulse[i]` and stays set until cleared, so the read value is the sum of the weights of all events seen since the last clear.
- R6: A read strobe returns the event register contents held in that cycle and clears the register at the following edge; a clear-status strobe also clears it.
- R7: An event pulse that coincides with any clear condition is kept in the register after that edge.
- R8: A write strobe loads the event-enable mask, and writing zero clears it; the mask is readable on `evt_en_q`.
- R9: Bit 6 is the OR of status byte bits 0 to 5 and 7, each ANDed with the matching bit of the 8-bit service-request enable mask; bit 6 of that mask has no effect.
- R10: A power-on pulse clears the event register; both enable masks are cleared by it when the power-on-clear flag is 1 and kept when it is 0.
- R11: A warm reset clears the event register but keeps both masks and the flag; a cold reset sets both masks to 0 and the flag to 1.
- R12: The power-on-clear flag is loaded by its own write strobe and is readable on `poc_flag_q`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Warm reset, asynchronous, active low |
| cold_rst_n | input | 1 | Cold reset for retained state, asynchronous, active low |
| power_on | input | 1 | One-cycle power-on event |
| evt_pulse | input | EVT_W | Event set pulses, one bit per event |
| ques_sum | input | 1 | Masked questionable-status summary |
| msg_avail | input | 1 | Output buffer holds unread data |
| clr_status | input | 1 | Clear-status command strobe |
| evt_rd | input | 1 | Event register read strobe (read clears) |
| evt_rd_data | output | EVT_W | Event register value in the read cycle |
| evt_en_wr | input | 1 | Event-enable mask write strobe |
| evt_en_wdata | input | EVT_W | Event-enable mask write data |
| evt_en_q | output | EVT_W | Current event-enable mask |
| srq_en_wr | input | 1 | Service-request mask write strobe |
| srq_en_wdata | input | 8 | Service-request mask write data |
| srq_en_q | output | 8 | Current service-request mask |
| poc_wr | input | 1 | Power-on-clear flag write strobe |
| poc_wdata | input | 1 | Power-on-clear flag write data |
| poc_flag_q | output | 1 | Current power-on-clear flag |
| status_byte | output | 8 | Status byte |

## Verification
The bench targets an event pulse that lands in the same cycle as a read. A design that lets the clear win would lose that event, and the next read would come back empty. It reads the register in the cycle of the strobe. A design that returns the post-clear value would show zero instead of the accumulated weight sum. After a clear-status it checks that bit 5 drops at once. A latched summary would keep reporting a stale event. Both power-on flag settings and a warm reset are exercised, so a mask that is cleared when it should be kept, or the reverse, shows up on the mask read-back ports. Mask vectors with bit 6 set, or with the reserved bits set, show whether request-service feeds back on itself or picks up bits that are always zero.

// File: rtl/sbu_pkg.sv
package sbu_pkg;
  localparam int SB_W    = 8;
  localparam int SB_QUES = 3;
  localparam int SB_MAV  = 4;
  localparam int SB_ESB  = 5;
  localparam int SB_RQS  = 6;
  typedef logic [SB_W-1:0] sbyte_t;
endpackage

// File: rtl/sbu_rst_sync.sv
module sbu_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] pipe_q;
  logic [STAGES-1:0] pipe_nxt;

  always_comb begin
    pipe_nxt = {pipe_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) pipe_q <= '0;
    else         pipe_q <= pipe_nxt;
  end

  assign srst_n = pipe_q[STAGES-1];
endmodule

// File: rtl/sbu_event_reg.sv
module sbu_event_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic         clr_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] bit_q;
  logic [W-1:0] bit_nxt;
  logic [W-1:0] bit_en;

  for (genvar i = 0; i < W; i++) begin : g_cell
    always_comb begin
      bit_en[i]  = set_i[i] | clr_i;
      bit_nxt[i] = set_i[i] | (bit_q[i] & ~clr_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         bit_q[i] <= 1'b0;
      else if (bit_en[i]) bit_q[i] <= bit_nxt[i];
    end
  end

  assign q_o = bit_q;

  // R5, R7: a pulsed bit is present after the edge, clear or not
  assert_set_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i != '0) |=> ((q_o & $past(set_i)) == $past(set_i)));

  // R6: a clear with no pulse empties the register
  assert_clear_empties_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && set_i == '0) |=> (q_o == '0));

  // R5: without pulse or clear the bits are sticky
  assert_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && set_i == '0) |=> $stable(q_o));
endmodule

// File: rtl/sbu_retained_reg.sv
module sbu_retained_reg #(
  parameter int          W       = 8,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  input  logic         pwr_clr_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] val_q;
  logic [W-1:0] val_nxt;
  logic         val_en;

  always_comb begin
    val_en  = wr_i | pwr_clr_i;
    val_nxt = wr_i ? wdata_i : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      val_q <= RST_VAL;
    else if (val_en) val_q <= val_nxt;
  end

  assign q_o = val_q;

  // R8: a write loads the written value
  assert_write_loads_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |=> (q_o == $past(wdata_i)));

  // R10: power-on clear empties the register
  assert_pwr_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_clr_i && !wr_i) |=> (q_o == '0));

  // R10, R11: otherwise the value is retained
  assert_retained_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!pwr_clr_i && !wr_i) |=> $stable(q_o));
endmodule

// File: rtl/sbu_summary.sv
module sbu_summary
  import sbu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] evt_q_i,
  input  logic [W-1:0] evt_en_i,
  input  logic         ques_i,
  input  logic         mav_i,
  input  sbyte_t       srq_en_i,
  output sbyte_t       sb_o
);
  sbyte_t base;
  logic   esb;
  logic   rqs;

  always_comb begin
    esb             = |(evt_q_i & evt_en_i);
    base            = '0;
    base[SB_QUES]   = ques_i;
    base[SB_MAV]    = mav_i;
    base[SB_ESB]    = esb;
    rqs             = |(base & srq_en_i & ~(sbyte_t'(1) << SB_RQS));
    sb_o            = base;
    sb_o[SB_RQS]    = rqs;
  end
endmodule

// File: rtl/status_byte_unit.sv
module status_byte_unit
  import sbu_pkg::*;
#(
  parameter int EVT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cold_rst_n,
  input  logic             power_on,
  input  logic [EVT_W-1:0] evt_pulse,
  input  logic             ques_sum,
  input  logic             msg_avail,
  input  logic             clr_status,
  input  logic             evt_rd,
  output logic [EVT_W-1:0] evt_rd_data,
  input  logic             evt_en_wr,
  input  logic [EVT_W-1:0] evt_en_wdata,
  output logic [EVT_W-1:0] evt_en_q,
  input  logic             srq_en_wr,
  input  logic [SB_W-1:0]  srq_en_wdata,
  output logic [SB_W-1:0]  srq_en_q,
  input  logic             poc_wr,
  input  logic             poc_wdata,
  output logic             poc_flag_q,
  output logic [SB_W-1:0]  status_byte
);
  logic             warm_srst_n;
  logic             cold_srst_n;
  logic             evt_clr;
  logic             mask_pwr_clr;
  logic [EVT_W-1:0] evt_q;

  sbu_rst_sync #(.STAGES(2)) u_warm_sync (
    .clk    (clk),
    .arst_n (rst_n & cold_rst_n),
    .srst_n (warm_srst_n)
  );

  sbu_rst_sync #(.STAGES(2)) u_cold_sync (
    .clk    (clk),
    .arst_n (cold_rst_n),
    .srst_n (cold_srst_n)
  );

  always_comb begin
    evt_clr      = evt_rd | clr_status | power_on;
    mask_pwr_clr = power_on & poc_flag_q;
  end

  sbu_event_reg #(.W(EVT_W)) u_evt (
    .clk   (clk),
    .rst_n (warm_srst_n),
    .set_i (evt_pulse),
    .clr_i (evt_clr),
    .q_o   (evt_q)
  );

  sbu_retained_reg #(.W(EVT_W), .RST_VAL('0)) u_evt_en (
    .clk       (clk),
    .rst_n     (cold_srst_n),
    .wr_i      (evt_en_wr),
    .wdata_i   (evt_en_wdata),
    .pwr_clr_i (mask_pwr_clr),
    .q_o       (evt_en_q)
  );

  sbu_retained_reg #(.W(SB_W), .RST_VAL('0)) u_srq_en (
    .clk       (clk),
    .rst_n     (cold_srst_n),
    .wr_i      (srq_en_wr),
    .wdata_i   (srq_en_wdata),
    .pwr_clr_i (mask_pwr_clr),
    .q_o       (srq_en_q)
  );

  sbu_retained_reg #(.W(1), .RST_VAL(1'b1)) u_poc (
    .clk       (clk),
    .rst_n     (cold_srst_n),
    .wr_i      (poc_wr),
    .wdata_i   (poc_wdata),
    .pwr_clr_i (1'b0),
    .q_o       (poc_flag_q)
  );

  sbu_summary #(.W(EVT_W)) u_sum (
    .evt_q_i  (evt_q),
    .evt_en_i (evt_en_q),
    .ques_i   (ques_sum),
    .mav_i    (msg_avail),
    .srq_en_i (srq_en_q),
    .sb_o     (status_byte)
  );

  assign evt_rd_data = evt_q;

  // R3: after a clearing read with no new pulse, bit 5 is gone
  assert_esb_drops_R3: assert property (@(posedge clk) disable iff (!warm_srst_n)
    (evt_rd && evt_pulse == '0) |=> !status_byte[SB_ESB]);

  // R2: reserved positions stay zero while the block runs
  assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!warm_srst_n)
    (status_byte[2:0] == 3'b000) && !status_byte[7]);
endmodule

// File: tb/status_byte_unit_test.sv
module status_byte_unit_test;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 9;
  // {evt set, evt enable, srq enable, ques, mav, expected status byte}
  localparam logic [33:0] VEC [0:NVEC-1] = '{
    {8'h00, 8'h00, 8'h00, 1'b0, 1'b0, 8'h00},
    {8'h1C, 8'h00, 8'h00, 1'b0, 1'b0, 8'h00},
    {8'h1C, 8'h04, 8'h00, 1'b0, 1'b0, 8'h20},
    {8'h1C, 8'h04, 8'h20, 1'b0, 1'b0, 8'h60},
    {8'h00, 8'hFF, 8'hFF, 1'b1, 1'b0, 8'h48},
    {8'h00, 8'hFF, 8'h10, 1'b0, 1'b1, 8'h50},
    {8'h80, 8'h80, 8'h08, 1'b0, 1'b1, 8'h30},
    {8'h01, 8'h02, 8'hFF, 1'b1, 1'b1, 8'h58},
    {8'h01, 8'h01, 8'h47, 1'b1, 1'b1, 8'h38}
  };

  logic       clk = 1'b0;
  logic       rst_n, cold_rst_n, power_on, ques_sum, msg_avail;
  logic       clr_status, evt_rd, evt_en_wr, srq_en_wr, poc_wr, poc_wdata;
  logic [7:0] evt_pulse, evt_en_wdata, srq_en_wdata;
  logic [7:0] evt_rd_data, evt_en_q, srq_en_q, status_byte;
  logic       poc_flag_q;
  int         checks = 0;
  int         errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  status_byte_unit uut (
    .clk(clk), .rst_n(rst_n), .cold_rst_n(cold_rst_n), .power_on(power_on),
    .evt_pulse(evt_pulse), .ques_sum(ques_sum), .msg_avail(msg_avail),
    .clr_status(clr_status), .evt_rd(evt_rd), .evt_rd_data(evt_rd_data),
    .evt_en_wr(evt_en_wr), .evt_en_wdata(evt_en_wdata), .evt_en_q(evt_en_q),
    .srq_en_wr(srq_en_wr), .srq_en_wdata(srq_en_wdata), .srq_en_q(srq_en_q),
    .poc_wr(poc_wr), .poc_wdata(poc_wdata), .poc_flag_q(poc_flag_q),
    .status_byte(status_byte)
  );

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic read_expect(string req, logic [7:0] exp);
    evt_rd = 1'b1;
    #1 check(req, evt_rd_data, exp);
    step();
    evt_rd = 1'b0;
  endtask

  task automatic write_masks(logic [7:0] ev, logic [7:0] sr);
    evt_en_wr = 1'b1; evt_en_wdata = ev;
    srq_en_wr = 1'b1; srq_en_wdata = sr;
    step();
    evt_en_wr = 1'b0; srq_en_wr = 1'b0;
  endtask

  task automatic pulse(logic [7:0] v);
    evt_pulse = v;
    step();
    evt_pulse = '0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 0; cold_rst_n = 0; power_on = 0; ques_sum = 0; msg_avail = 0;
    clr_status = 0; evt_rd = 0; evt_en_wr = 0; srq_en_wr = 0; poc_wr = 0;
    poc_wdata = 0; evt_pulse = '0; evt_en_wdata = '0; srq_en_wdata = '0;
    repeat (3) step();
    rst_n = 1; cold_rst_n = 1;
    repeat (3) step();

    // R11, R12: cold reset state
    check("R11 reset status byte", status_byte, 8'h00);
    check("R11 reset evt enable", evt_en_q, 8'h00);
    check("R11 reset srq enable", srq_en_q, 8'h00);
    check("R12 reset poc flag", {7'b0, poc_flag_q}, 8'h01);

    // Vector walk: R1, R2, R4, R9, R5, R6
    for (int i = 0; i < NVEC; i++) begin
      logic [7:0] vset, ven, vsrq, vexp;
      logic vq, vm;
      {vset, ven, vsrq, vq, vm, vexp} = VEC[i];
      evt_rd = 1'b1; step(); evt_rd = 1'b0;
      evt_en_wr = 1; evt_en_wdata = ven; srq_en_wr = 1; srq_en_wdata = vsrq;
      evt_pulse = vset; ques_sum = vq; msg_avail = vm;
      step();
      evt_en_wr = 0; srq_en_wr = 0; evt_pulse = '0;
      check($sformatf("R1 R2 R4 R9 vector %0d", i), status_byte, vexp);
      read_expect($sformatf("R5 R6 vector %0d read", i), vset);
      ques_sum = 0; msg_avail = 0;
    end

    // R5: accumulated weights 4+8+16 = 28; R6: read clears
    write_masks(8'h00, 8'h00);
    pulse(8'h04); pulse(8'h08); pulse(8'h10);
    read_expect("R5 weight sum", 8'd28);
    read_expect("R6 cleared by read", 8'h00);

    // R7: pulse coinciding with a read survives
    pulse(8'h01);
    evt_rd = 1'b1; evt_pulse = 8'h02;
    #1 check("R7 read returns old value", evt_rd_data, 8'h01);
    step();
    evt_rd = 1'b0; evt_pulse = '0;
    read_expect("R7 new event kept", 8'h02);

    // R3, R6: clear-status drops bit 5 at once
    write_masks(8'h20, 8'h00);
    pulse(8'h20);
    check("R4 esb set", status_byte, 8'h20);
    clr_status = 1'b1; step(); clr_status = 1'b0;
    check("R3 esb after clear-status", status_byte, 8'h00);
    read_expect("R6 clear-status empties", 8'h00);

    // R3: message-available follows without a clock
    msg_avail = 1'b1;
    #1 check("R3 mav immediate", status_byte, 8'h10);
    msg_avail = 1'b0;
    #1 check("R3 mav drop immediate", status_byte, 8'h00);
    ques_sum = 1'b1;
    #1 check("R3 ques immediate", status_byte, 8'h08);
    ques_sum = 1'b0;
    step();

    // R8: writing zero clears the enable mask
    pulse(8'h20);
    check("R8 esb before zero write", status_byte, 8'h20);
    write_masks(8'h00, 8'h00);
    check("R8 enable readback", evt_en_q, 8'h00);
    check("R8 esb masked", status_byte, 8'h00);
    read_expect("R8 event still held", 8'h20);

    // R10: power-on with flag 1 clears masks and events
    write_masks(8'h20, 8'h20);
    pulse(8'h20);
    check("R10 before power-on", status_byte, 8'h60);
    power_on = 1'b1; step(); power_on = 1'b0;
    check("R10 evt enable cleared", evt_en_q, 8'h00);
    check("R10 srq enable cleared", srq_en_q, 8'h00);
    read_expect("R10 events cleared", 8'h00);

    // R12: flag write; R10: flag 0 keeps masks
    poc_wr = 1'b1; poc_wdata = 1'b0; step(); poc_wr = 1'b0;
    check("R12 poc readback", {7'b0, poc_flag_q}, 8'h00);
    write_masks(8'h20, 8'h20);
    pulse(8'h20);
    power_on = 1'b1; step(); power_on = 1'b0;
    check("R10 evt enable kept", evt_en_q, 8'h20);
    check("R10 srq enable kept", srq_en_q, 8'h20);
    check("R10 events gone", status_byte, 8'h00);
    pulse(8'h20);
    check("R10 kept masks active", status_byte, 8'h60);

    // R11: warm reset keeps masks and flag, clears events
    rst_n = 1'b0; repeat (2) step();
    rst_n = 1'b1; repeat (3) step();
    check("R11 warm evt enable", evt_en_q, 8'h20);
    check("R11 warm srq enable", srq_en_q, 8'h20);
    check("R11 warm poc flag", {7'b0, poc_flag_q}, 8'h00);
    check("R11 warm status byte", status_byte, 8'h00);
    read_expect("R11 warm events", 8'h00);

    // R11: cold reset restores defaults
    cold_rst_n = 1'b0; repeat (2) step();
    cold_rst_n = 1'b1; repeat (3) step();
    check("R11 cold evt enable", evt_en_q, 8'h00);
    check("R11 cold srq enable", srq_en_q, 8'h00);
    check("R12 cold poc flag", {7'b0, poc_flag_q}, 8'h01);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule